// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block tracks the position of a rotary or linear quadrature encoder. Two phase inputs, A and B, are brought into the clock domain and compared with their previous samples. A mode field then decides which phase transitions move the count. There are four modes: counting on the internal clock, half resolution on phase A transitions, half resolution on phase B transitions, and full resolution on every transition of either phase. The direction comes from the phase relationship. When A leads B the count goes up. When B leads A the count goes down.

The count runs from zero up to a programmable ceiling and wraps at both ends. Each wrap produces a one-cycle pulse on an output pin. Software uses a small word-wide register port to enable counting, pick the mode, load or read the count, and program the ceiling. The ceiling can be programmed either immediately or through a shadow copy that loads into the active ceiling when software writes an update trigger. Register map, with the address in brackets: control [0], count [1], active ceiling [2], ceiling shadow [3]. Control bits: bit 0 enable, bit 1 ceiling preload enable, bits 3:2 mode, bit 4 update trigger, bit 5 direction (read-only).

Top module: `qenc_counter`

## Requirements
- R1: After reset the count reads 0, the control register reads 0, the active ceiling reads the parameter CEIL_RESET (all ones by default) and the wrap pulse is low.
- R2: With mode 0 (control bits 3:2 = 0) and enable set, the count rises by one on every clock, and the phase inputs have no effect.
- R3: In mode 1, only transitions of A change the count. The count goes up when A differs from B after the transition and down when they are equal. B transitions leave the count unchanged.
- R4: In mode 2, only transitions of B change the count. The count goes up when A equals B after the transition and down when they differ. A transitions leave the count unchanged.
- R5: In mode 3, every transition of A or B changes the count, so one full phase cycle gives four counts: up for the sequence 00,10,11,01 of (A,B) and down for the reverse.
- R6: A synchronised sample in which A and B both change against the previous sample counts as an invalid transition and leaves the count unchanged.
- R7: While enable is 0 the count holds its value, and phase transitions seen during that time are not counted after counting is enabled again.
- R8: Counting up from a value at or above the ceiling gives 0. Counting down from 0 gives the ceiling. Each such wrap raises the wrap output for exactly one clock.
- R9: With preload enable 0, a ceiling write reaches the active ceiling on the next clock edge.
- R10: With preload enable 1, a ceiling write changes only the shadow (address 3). A control write with bit 4 set copies the shadow into the active ceiling. Bit 4 reads back as 0.
- R11: A count write loads the written value on the next clock edge, replacing any step counted in that cycle.
- R12: Control bit 5 reads 1 after a counted step down and 0 after a counted step up, and it is updated on every counted step.
- R13: A phase change on a pin shows in the count three clock edges later: two synchroniser stages and the count register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Register read data, combinational from reg_addr |
| wrap_evt | output | 1 | One-cycle pulse on each count wrap |

## Verification
The bench builds the counter with CNT_W = 8 and two synchroniser stages. This keeps the reset ceiling at 255, and with a ceiling of 20 both wrap directions are reached in a few encoder steps. The two-stage setting fixes the phase-to-count latency at three edges. That fixed latency lets the bench line up a count write exactly with the edge that carries an encoder step, which is how it tests write priority. Every mode is driven through full forward and reverse phase cycles. The bench also drives a simultaneous A/B change, so both the decode direction rules and the rejection of invalid transitions are exercised.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

   localparam int ADDR_W = 2;

   typedef enum logic [1:0] {
      QM_CLOCK = 2'd0,
      QM_X2A   = 2'd1,
      QM_X2B   = 2'd2,
      QM_X4    = 2'd3
   } qenc_mode_e;

   localparam logic [ADDR_W-1:0] RA_CTRL   = 2'd0;
   localparam logic [ADDR_W-1:0] RA_COUNT  = 2'd1;
   localparam logic [ADDR_W-1:0] RA_CEIL   = 2'd2;
   localparam logic [ADDR_W-1:0] RA_SHADOW = 2'd3;

   localparam int CB_EN   = 0;
   localparam int CB_PRE  = 1;
   localparam int CB_MODE = 2;
   localparam int CB_UPD  = 4;
   localparam int CB_DIR  = 5;
   localparam int CTRL_BITS = 6;

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
   parameter int N      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pin_i,
   output logic [N-1:0] lvl_o,
   output logic [N-1:0] chg_o
);

   initial begin
      assert (STAGES >= 2) else $error("qenc_sync: STAGES must be at least 2");
      assert (N >= 1) else $error("qenc_sync: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      logic              prev_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
         end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_i[i]};
            prev_q  <= chain_q[STAGES-1];
         end
      end

      assign lvl_o[i] = chain_q[STAGES-1];
      assign chg_o[i] = chain_q[STAGES-1] ^ prev_q;
   end

endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
   import qenc_pkg::*;
(
   input  qenc_mode_e mode_i,
   input  logic       en_i,
   input  logic       a_i,
   input  logic       b_i,
   input  logic       a_chg_i,
   input  logic       b_chg_i,
   output logic       step_o,
   output logic       down_o
);

   logic a_only, b_only, a_down, b_down;

   assign a_only = a_chg_i & ~b_chg_i;
   assign b_only = b_chg_i & ~a_chg_i;
   // after an A transition, equal phases mean B leads
   assign a_down = (a_i == b_i);
   // after a B transition, unequal phases mean B leads
   assign b_down = (a_i != b_i);

   always_comb begin
      step_o = 1'b0;
      down_o = 1'b0;
      unique case (mode_i)
         QM_CLOCK: begin
            step_o = en_i;
            down_o = 1'b0;
         end
         QM_X2A: begin
            step_o = en_i & a_only;
            down_o = a_down;
         end
         QM_X2B: begin
            step_o = en_i & b_only;
            down_o = b_down;
         end
         QM_X4: begin
            step_o = en_i & (a_only | b_only);
            down_o = a_only ? a_down : b_down;
         end
         default: begin
            step_o = 1'b0;
            down_o = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/qenc_regs.sv
module qenc_regs
   import qenc_pkg::*;
#(
   parameter int               W          = 16,
   parameter logic [W-1:0]     CEIL_RESET = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [W-1:0]      wdata_i,
   output logic              en_o,
   output logic              pre_o,
   output qenc_mode_e        mode_o,
   output logic [W-1:0]      ceil_o,
   output logic [W-1:0]      shadow_o,
   output logic              cnt_wr_o
);

   logic ctrl_wr, ceil_wr, upd;

   assign ctrl_wr  = we_i && (addr_i == RA_CTRL);
   assign ceil_wr  = we_i && (addr_i == RA_CEIL);
   assign cnt_wr_o = we_i && (addr_i == RA_COUNT);
   assign upd      = ctrl_wr && wdata_i[CB_UPD];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o   <= 1'b0;
         pre_o  <= 1'b0;
         mode_o <= QM_CLOCK;
      end else if (ctrl_wr) begin
         en_o   <= wdata_i[CB_EN];
         pre_o  <= wdata_i[CB_PRE];
         mode_o <= qenc_mode_e'(wdata_i[CB_MODE +: 2]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ceil_o   <= CEIL_RESET;
         shadow_o <= CEIL_RESET;
      end else begin
         if (ceil_wr) begin
            shadow_o <= wdata_i;
            if (!pre_o) ceil_o <= wdata_i;
         end
         if (upd) ceil_o <= shadow_o;
      end
   end

   // R9
   direct_ceil_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ceil_wr && !pre_o) |=> (ceil_o == $past(wdata_i)));
   // R10
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ceil_wr && pre_o) |=> $stable(ceil_o));
   // R10
   update_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> (ceil_o == $past(shadow_o)));

endmodule

// File: rtl/qenc_core.sv
module qenc_core #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step_i,
   input  logic         down_i,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic [W-1:0] ceil_i,
   output logic [W-1:0] cnt_o,
   output logic         dir_o,
   output logic         wrap_o
);

   logic at_top, at_bot, wrap_nxt;
   logic [W-1:0] cnt_nxt;

   assign at_top = (cnt_o >= ceil_i);
   assign at_bot = (cnt_o == '0);

   always_comb begin
      cnt_nxt  = cnt_o;
      wrap_nxt = 1'b0;
      if (load_i) begin
         cnt_nxt = load_val_i;
      end else if (step_i) begin
         if (down_i) begin
            cnt_nxt  = at_bot ? ceil_i : cnt_o - 1'b1;
            wrap_nxt = at_bot;
         end else begin
            cnt_nxt  = at_top ? '0 : cnt_o + 1'b1;
            wrap_nxt = at_top;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o  <= '0;
         dir_o  <= 1'b0;
         wrap_o <= 1'b0;
      end else begin
         cnt_o  <= cnt_nxt;
         wrap_o <= wrap_nxt;
         if (step_i && !load_i) dir_o <= down_i;
      end
   end

   // R7
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_i && !load_i) |=> $stable(cnt_o));
   // R8
   wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !down_i && !load_i && (cnt_o >= ceil_i)) |=> ((cnt_o == '0) && wrap_o));
   // R8
   wrap_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && down_i && !load_i && (cnt_o == '0)) |=> ((cnt_o == $past(ceil_i)) && wrap_o));
   // R11
   load_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> ((cnt_o == $past(load_val_i)) && !wrap_o));
   // R12
   dir_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i) |=> (dir_o == $past(down_i)));

endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
   import qenc_pkg::*;
#(
   parameter int                 CNT_W       = 16,
   parameter int                 SYNC_STAGES = 2,
   parameter logic [CNT_W-1:0]   CEIL_RESET  = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enc_a,
   input  logic              enc_b,
   input  logic              reg_we,
   input  logic [1:0]        reg_addr,
   input  logic [CNT_W-1:0]  reg_wdata,
   output logic [CNT_W-1:0]  reg_rdata,
   output logic              wrap_evt
);

   localparam int PAD_W = CNT_W - CTRL_BITS;

   initial begin
      assert (CNT_W >= CTRL_BITS) else $error("qenc_counter: CNT_W too narrow for control word");
   end

   logic [1:0]       lvl, chg;
   logic             en, pre, step, down, cnt_wr, dir;
   qenc_mode_e       mode;
   logic [CNT_W-1:0] ceil_act, ceil_shd, cnt;
   logic [CNT_W-1:0] ctrl_word;

   qenc_sync #(.N(2), .STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i ({enc_b, enc_a}),
      .lvl_o (lvl),
      .chg_o (chg)
   );

   qenc_regs #(.W(CNT_W), .CEIL_RESET(CEIL_RESET)) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_i     (reg_we),
      .addr_i   (reg_addr),
      .wdata_i  (reg_wdata),
      .en_o     (en),
      .pre_o    (pre),
      .mode_o   (mode),
      .ceil_o   (ceil_act),
      .shadow_o (ceil_shd),
      .cnt_wr_o (cnt_wr)
   );

   qenc_decode decode_i (
      .mode_i  (mode),
      .en_i    (en),
      .a_i     (lvl[0]),
      .b_i     (lvl[1]),
      .a_chg_i (chg[0]),
      .b_chg_i (chg[1]),
      .step_o  (step),
      .down_o  (down)
   );

   qenc_core #(.W(CNT_W)) core_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .step_i     (step),
      .down_i     (down),
      .load_i     (cnt_wr),
      .load_val_i (reg_wdata),
      .ceil_i     (ceil_act),
      .cnt_o      (cnt),
      .dir_o      (dir),
      .wrap_o     (wrap_evt)
   );

   if (PAD_W > 0) begin : g_pad
      assign ctrl_word = {{PAD_W{1'b0}}, dir, 1'b0, mode, pre, en};
   end else begin : g_nopad
      assign ctrl_word = {dir, 1'b0, mode, pre, en};
   end

   always_comb begin
      unique case (reg_addr)
         RA_CTRL:   reg_rdata = ctrl_word;
         RA_COUNT:  reg_rdata = cnt;
         RA_CEIL:   reg_rdata = ceil_act;
         RA_SHADOW: reg_rdata = ceil_shd;
         default:   reg_rdata = '0;
      endcase
   end

   // R6
   invalid_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode != QM_CLOCK) && chg[0] && chg[1]) |-> !step);
   // R7
   enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !step);
   // R12
   clock_mode_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == QM_CLOCK) |-> !down);

endmodule

// File: tb/qenc_counter_tb.sv
module qenc_counter_tb_top;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         enc_a = 1'b0, enc_b = 1'b0;
   logic         reg_we = 1'b0;
   logic [1:0]   reg_addr = 2'd0;
   logic [W-1:0] reg_wdata = '0;
   logic [W-1:0] reg_rdata;
   logic         wrap_evt;

   int total = 0;
   int fails = 0;

   always #5 clk = ~clk;

   qenc_counter #(.CNT_W(W), .SYNC_STAGES(2)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .enc_a     (enc_a),
      .enc_b     (enc_b),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .wrap_evt  (wrap_evt)
   );

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic logic [W-1:0] ctl(input bit en, input bit pre, input int md, input bit upd);
      return W'({upd, md[1:0], pre, en});
   endfunction

   task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int d);
      reg_addr = a;
      #1;
      d = int'(reg_rdata);
   endtask

   task automatic move(input logic na, input logic nb, output int wraps);
      enc_a = na; enc_b = nb; wraps = 0;
      repeat (4) begin
         @(negedge clk);
         if (wrap_evt) wraps++;
      end
   endtask

   task automatic t_reset();
      int v;
      rd(2'd1, v); check("R1 count", v, 0);
      rd(2'd0, v); check("R1 ctrl", v, 0);
      rd(2'd2, v); check("R1 ceiling", v, 255);
      check("R1 wrap", int'(wrap_evt), 0);
   endtask

   task automatic t_clock_mode();
      int v;
      enc_a = 1'b1;
      wr(2'd0, ctl(1, 0, 0, 0));
      repeat (9) @(negedge clk);
      enc_a = 1'b0;
      wr(2'd0, ctl(0, 0, 0, 0));
      rd(2'd1, v); check("R2 clock count", v, 10);
      rd(2'd0, v); check("R2 dir up", (v >> 5) & 1, 0);
   endtask

   task automatic t_x4();
      int v, w;
      repeat (4) @(negedge clk);
      wr(2'd1, 8'd100);
      wr(2'd0, ctl(1, 0, 3, 0));
      move(1, 0, w);
      // R13 latency: three edges fit inside the four-cycle move window
      rd(2'd1, v); check("R13 R5 first step", v, 101);
      move(1, 1, w); move(0, 1, w); move(0, 0, w);
      rd(2'd1, v); check("R5 four up", v, 104);
      move(0, 1, w);
      rd(2'd0, v); check("R12 dir down", (v >> 5) & 1, 1);
      move(1, 1, w); move(1, 0, w); move(0, 0, w);
      rd(2'd1, v); check("R5 four down", v, 100);
   endtask

   task automatic t_x2a();
      int v, w;
      wr(2'd0, ctl(1, 0, 1, 0));
      move(1, 0, w); rd(2'd1, v); check("R3 A rise up", v, 101);
      move(1, 1, w); rd(2'd1, v); check("R3 B ignored", v, 101);
      move(0, 1, w); move(0, 0, w);
      rd(2'd1, v); check("R3 cycle +2", v, 102);
      move(0, 1, w); move(1, 1, w);
      rd(2'd1, v); check("R3 A rise down", v, 101);
      move(1, 0, w); move(0, 0, w);
      rd(2'd1, v); check("R3 reverse -2", v, 100);
   endtask

   task automatic t_x2b();
      int v, w;
      wr(2'd0, ctl(1, 0, 2, 0));
      move(1, 0, w); rd(2'd1, v); check("R4 A ignored", v, 100);
      move(1, 1, w); rd(2'd1, v); check("R4 B rise up", v, 101);
      move(0, 1, w); move(0, 0, w);
      rd(2'd1, v); check("R4 cycle +2", v, 102);
      move(0, 1, w);
      rd(2'd1, v); check("R4 B rise down", v, 101);
      move(1, 1, w); move(1, 0, w); move(0, 0, w);
      rd(2'd1, v); check("R4 reverse -2", v, 100);
   endtask

   task automatic t_invalid();
      int v, w;
      wr(2'd0, ctl(1, 0, 3, 0));
      move(1, 1, w); move(0, 0, w);
      rd(2'd1, v); check("R6 double change", v, 100);
   endtask

   task automatic t_freeze();
      int v, w;
      wr(2'd0, ctl(0, 0, 3, 0));
      move(1, 0, w); move(1, 1, w); move(0, 1, w); move(0, 0, w);
      rd(2'd1, v); check("R7 frozen", v, 100);
      wr(2'd0, ctl(1, 0, 3, 0));
      repeat (2) @(negedge clk);
      rd(2'd1, v); check("R7 no late count", v, 100);
      move(1, 0, w);
      rd(2'd1, v); check("R7 resume", v, 101);
   endtask

   task automatic t_priority();
      int v;
      enc_b = 1'b1;
      repeat (2) @(negedge clk);
      wr(2'd1, 8'd50);
      repeat (2) @(negedge clk);
      rd(2'd1, v); check("R11 write wins", v, 50);
   endtask

   task automatic t_wrap();
      int v, w;
      wr(2'd2, 8'd20);
      rd(2'd2, v); check("R9 direct ceiling", v, 20);
      wr(2'd1, 8'd20);
      move(0, 1, w);
      rd(2'd1, v); check("R8 up wrap", v, 0);
      check("R8 up pulse", w, 1);
      move(1, 1, w);
      rd(2'd1, v); check("R8 down wrap", v, 20);
      check("R8 down pulse", w, 1);
   endtask

   task automatic t_preload();
      int v;
      wr(2'd0, ctl(1, 1, 3, 0));
      wr(2'd2, 8'd30);
      rd(2'd2, v); check("R10 active held", v, 20);
      rd(2'd3, v); check("R10 shadow", v, 30);
      wr(2'd0, ctl(1, 1, 3, 1));
      rd(2'd2, v); check("R10 update load", v, 30);
      rd(2'd0, v); check("R10 trigger reads 0", (v >> 4) & 1, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_clock_mode();
      t_x4();
      t_x2a();
      t_x2b();
      t_invalid();
      t_freeze();
      t_priority();
      t_wrap();
      t_preload();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule